// File: doc/BRIEF.md
# Bidirectional Multi-Mode Bus Register

This block joins two 18-bit ports with two independent storage paths: one carries port A data to port B and the other carries port B data to port A. Each path has its own latch-enable, strobe and output-enable inputs. With latch-enable high, the path is transparent and its output follows its input in the same cycle. With latch-enable low, the path holds its stored word while its strobe stays at a constant level, and loads a new word when its strobe rises.

All logic runs on one system clock `clk`. The strobes are sampled on that clock, and a rise is detected when a strobe is seen high after it was seen low. The A-to-B enable is active high and the B-to-A enable is active low. Three-state ports are modelled as a data bus plus a drive flag. When the drive flag is low, the data bus has no meaning, but the storage behind it keeps working.

Top module: `bbr_bus_register`

## Requirements
- R1: An asynchronous active-low reset clears both stored words to zero. While reset is held and a path's latch-enable is low, that path's output reads zero with no clock edge needed.
- R2: While `le_ab` is high, `b_out` equals `a_in` in the same cycle, with no clock edge in between.
- R3: While `le_ab` is low and `clk_ab` does not rise, `b_out` keeps its value whatever `a_in` does.
- R4: While `le_ab` is low, the first system edge at which `clk_ab` is sampled high after being sampled low loads `a_in` as sampled at that edge, and `b_out` shows it from that edge on.
- R5: `b_drive` is 1 exactly when `oe_ab` is 1. Loads, holds and pass-through in the A-to-B path keep working while `b_drive` is 0.
- R6: The B-to-A path follows R2 to R4 with `le_ba`, `clk_ba`, `b_in` and `a_out`.
- R7: `a_drive` is 1 exactly when `oe_ba_n` is 0.
- R8: When latch-enable goes low while the strobe is already high, the output keeps the input word sampled at the last system edge at which latch-enable was high.
- R9: Activity on one path (data, latch-enable, strobe or enable) never changes the other path's output.
- R10: A falling strobe loads nothing. The stored word is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Port A input word |
| le_ab | input | 1 | A-to-B latch-enable, high = transparent |
| clk_ab | input | 1 | A-to-B load strobe, acts on its rise |
| oe_ab | input | 1 | A-to-B output enable, active high |
| b_out | output | WIDTH | Port B output word |
| b_drive | output | 1 | Port B drive flag (0 = high impedance) |
| b_in | input | WIDTH | Port B input word |
| le_ba | input | 1 | B-to-A latch-enable, high = transparent |
| clk_ba | input | 1 | B-to-A load strobe, acts on its rise |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | WIDTH | Port A output word |
| a_drive | output | 1 | Port A drive flag (0 = high impedance) |

## Verification
A stored word that is wrong stays hidden while latch-enable is high, because the output then shows the input directly. The fault appears on the first cycle after latch-enable drops. A strobe edge detector that is wrong either loads on a static or falling strobe or misses a rise. Either way the output differs from the expected word one system edge after the strobe change. The stimulus therefore holds, raises and drops each strobe with the input word changing at every step. It also loads a word while the drive flag is off, so that the stored value can be read back once the flag is on again.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

    // Operating mode of one storage path for the current cycle
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } lane_mode_e;

    // Polarity of a path's output enable
    typedef enum logic {
        OE_ACT_HIGH = 1'b0,
        OE_ACT_LOW  = 1'b1
    } oe_pol_e;

endpackage

// File: rtl/bbr_edge_sense.sv
module bbr_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A rise is a high sample after a low one
    assign rise = level & ~st_q.prev;

endmodule

// File: rtl/bbr_mode_decode.sv
module bbr_mode_decode
    import bbr_pkg::*;
(
    input  logic       le,
    input  logic       rise,
    output lane_mode_e mode
);

    // Transparency outranks the strobe
    always_comb begin
        if (le) begin
            mode = MODE_PASS;
        end else if (rise) begin
            mode = MODE_CAPTURE;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/bbr_lane.sv
module bbr_lane
    import bbr_pkg::*;
#(
    parameter int      WIDTH  = 18,
    parameter oe_pol_e OE_POL = OE_ACT_HIGH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             le,
    input  logic             strobe,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } lane_st_t;

    lane_st_t   st_d, st_q;
    logic       strobe_rise;
    lane_mode_e mode;

    bbr_edge_sense u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (strobe),
        .rise  (strobe_rise)
    );

    bbr_mode_decode u_dec (
        .le   (le),
        .rise (strobe_rise),
        .mode (mode)
    );

    // Storage keeps tracking the input while transparent, so a drop of
    // latch-enable leaves the last seen word behind
    always_comb begin
        st_d = st_q;
        case (mode)
            MODE_PASS,
            MODE_CAPTURE: st_d.data = din;
            default:      st_d.data = st_q.data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = (mode == MODE_PASS) ? din : st_q.data;

    generate
        if (OE_POL == OE_ACT_HIGH) begin : g_oe_high
            assign drive = oe;
        end else begin : g_oe_low
            assign drive = ~oe;
        end
    endgenerate

endmodule

// File: rtl/bbr_bus_register.sv
module bbr_bus_register
    import bbr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             le_ab,
    input  logic             clk_ab,
    input  logic             oe_ab,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    input  logic [WIDTH-1:0] b_in,
    input  logic             le_ba,
    input  logic             clk_ba,
    input  logic             oe_ba_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive
);

    localparam int NLANE   = 2;
    localparam int LANE_AB = 0;
    localparam int LANE_BA = 1;

    logic [NLANE-1:0][WIDTH-1:0] ln_din;
    logic [NLANE-1:0][WIDTH-1:0] ln_dout;
    logic [NLANE-1:0]            ln_le;
    logic [NLANE-1:0]            ln_strobe;
    logic [NLANE-1:0]            ln_oe;
    logic [NLANE-1:0]            ln_drive;

    assign ln_din[LANE_AB]    = a_in;
    assign ln_le[LANE_AB]     = le_ab;
    assign ln_strobe[LANE_AB] = clk_ab;
    assign ln_oe[LANE_AB]     = oe_ab;

    assign ln_din[LANE_BA]    = b_in;
    assign ln_le[LANE_BA]     = le_ba;
    assign ln_strobe[LANE_BA] = clk_ba;
    assign ln_oe[LANE_BA]     = oe_ba_n;

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            localparam oe_pol_e POL = (g == LANE_AB) ? OE_ACT_HIGH : OE_ACT_LOW;
            bbr_lane #(
                .WIDTH  (WIDTH),
                .OE_POL (POL)
            ) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .din    (ln_din[g]),
                .le     (ln_le[g]),
                .strobe (ln_strobe[g]),
                .oe     (ln_oe[g]),
                .dout   (ln_dout[g]),
                .drive  (ln_drive[g])
            );
        end
    endgenerate

    assign b_out   = ln_dout[LANE_AB];
    assign b_drive = ln_drive[LANE_AB];
    assign a_out   = ln_dout[LANE_BA];
    assign a_drive = ln_drive[LANE_BA];

endmodule

// File: rtl/bbr_bus_register_chk.sv
module bbr_bus_register_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic             le_ab,
    input logic             clk_ab,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_in,
    input logic             le_ba,
    input logic             clk_ba,
    input logic [WIDTH-1:0] a_out
);

    // Edges seen since reset, saturating; history checks wait for two
    logic [1:0] seen_q;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 2'd0;
        end else if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    assign armed = (seen_q >= 2'd2);

    p_pass_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        le_ab |-> (b_out == a_in));

    p_pass_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        le_ba |-> (a_out == b_in));

    p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !le_ab && $past(!le_ab) && !($past(clk_ab) && !$past(clk_ab, 2)))
        |-> $stable(b_out));

    p_hold_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !le_ba && $past(!le_ba) && !($past(clk_ba) && !$past(clk_ba, 2)))
        |-> $stable(a_out));

    p_capture_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !le_ab && $rose(clk_ab)) |=> (le_ab || (b_out == $past(a_in))));

    p_capture_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !le_ba && $rose(clk_ba)) |=> (le_ba || (a_out == $past(b_in))));

    p_le_fall_ab_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(le_ab)) |-> (b_out == $past(a_in)));

    p_le_fall_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(le_ba)) |-> (a_out == $past(b_in)));

endmodule

bind bbr_bus_register bbr_bus_register_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_in   (a_in),
    .le_ab  (le_ab),
    .clk_ab (clk_ab),
    .b_out  (b_out),
    .b_in   (b_in),
    .le_ba  (le_ba),
    .clk_ba (clk_ba),
    .a_out  (a_out)
);

// File: tb/bbr_bus_register_tb.sv
module bbr_bus_register_tb;

    localparam int W    = 18;
    localparam int NVEC = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         le_ab, clk_ab, oe_ab;
    logic         le_ba, clk_ba, oe_ba_n;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bbr_bus_register #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_in    (a_in),
        .le_ab   (le_ab),
        .clk_ab  (clk_ab),
        .oe_ab   (oe_ab),
        .b_out   (b_out),
        .b_drive (b_drive),
        .b_in    (b_in),
        .le_ba   (le_ba),
        .clk_ba  (clk_ba),
        .oe_ba_n (oe_ba_n),
        .a_out   (a_out),
        .a_drive (a_drive)
    );

    typedef struct packed {
        logic         le;
        logic         ck;
        logic         oe;
        logic [W-1:0] din;
        logic         exp_drv;
        logic [W-1:0] exp_out;
    } vec_t;

    // A-to-B walk; B-to-A stays quiet with enable on
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 18'h12345, 1'b1, 18'h00000}, // R3 hold after reset
        '{1'b0, 1'b1, 1'b1, 18'h0AAAA, 1'b1, 18'h0AAAA}, // R4 rise loads
        '{1'b0, 1'b1, 1'b1, 18'h15555, 1'b1, 18'h0AAAA}, // R3 static high
        '{1'b0, 1'b0, 1'b1, 18'h3FFFF, 1'b1, 18'h0AAAA}, // R10 fall ignored
        '{1'b1, 1'b0, 1'b1, 18'h3C3C3, 1'b1, 18'h3C3C3}, // R2 transparent
        '{1'b1, 1'b1, 1'b1, 18'h00F0F, 1'b1, 18'h00F0F}, // R2 transparent, strobe high
        '{1'b0, 1'b1, 1'b1, 18'h2AAAA, 1'b1, 18'h00F0F}, // R8 le drops, strobe high
        '{1'b0, 1'b0, 1'b0, 18'h11111, 1'b0, 18'h00F0F}, // R5 disabled
        '{1'b0, 1'b1, 1'b0, 18'h22222, 1'b0, 18'h22222}, // R5 load while disabled
        '{1'b0, 1'b1, 1'b1, 18'h33333, 1'b1, 18'h22222}  // R5 re-enabled shows load
    };

    task automatic chk_word(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        a_in    = '0;  b_in   = '0;
        le_ab   = 1'b0; clk_ab = 1'b0; oe_ab   = 1'b1;
        le_ba   = 1'b0; clk_ba = 1'b0; oe_ba_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk_word("R1 reset b_out", b_out, '0);
        chk_word("R1 reset a_out", a_out, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            le_ab  = VEC[i].le;
            clk_ab = VEC[i].ck;
            oe_ab  = VEC[i].oe;
            a_in   = VEC[i].din;
            step();
            chk_bit($sformatf("R5 table %0d b_drive", i), b_drive, VEC[i].exp_drv);
            chk_word($sformatf("table %0d b_out (R2 R3 R4 R5 R8 R10)", i), b_out, VEC[i].exp_out);
            chk_word($sformatf("R9 table %0d a_out quiet", i), a_out, '0);
            chk_bit($sformatf("R7 table %0d a_drive", i), a_drive, 1'b1);
        end

        // B-to-A directed; A-to-B stored word is 0x22222 with strobe high
        le_ba = 1'b1; b_in = 18'h1D2E3;
        step();
        chk_word("R6 transparent a_out", a_out, 18'h1D2E3);
        chk_bit("R7 enable low drives", a_drive, 1'b1);

        le_ba = 1'b0; b_in = 18'h00001;
        step();
        chk_word("R6 hold a_out", a_out, 18'h1D2E3);

        clk_ba = 1'b1; b_in = 18'h20000;
        step();
        chk_word("R6 capture a_out", a_out, 18'h20000);

        b_in = 18'h0FFFF; oe_ba_n = 1'b1;
        step();
        chk_bit("R7 enable high floats", a_drive, 1'b0);

        oe_ba_n = 1'b0;
        step();
        chk_bit("R7 enable low again", a_drive, 1'b1);
        chk_word("R6 static strobe hold", a_out, 18'h20000);
        chk_word("R9 b_out untouched by B-to-A", b_out, 18'h22222);

        // Same-cycle pass-through, then drop latch-enable with strobe high
        le_ab = 1'b1; a_in = 18'h0BEEF;
        #2;
        chk_word("R2 pass without edge", b_out, 18'h0BEEF);
        step();
        le_ab = 1'b0; a_in = 18'h00000;
        step();
        chk_word("R8 keeps last transparent word", b_out, 18'h0BEEF);

        // Asynchronous reset in mid-cycle
        rst_n = 1'b0;
        #2;
        chk_word("R1 async clear b_out", b_out, '0);
        chk_word("R1 async clear a_out", a_out, '0);
        step();
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule